// File: doc/BRIEF.md
# Single-Cycle RISC Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. Its instruction set is small: seven three-register operations (add, subtract, and, or, xor, nor and signed set-less-than), a word load, a word store and a branch taken when two registers are equal. Instruction storage and data storage are two separate internal arrays, so a fetch and a data access can both happen in the same cycle.

Control works in two levels. A main decoder looks only at the opcode. It produces the steering bits for the datapath and a 2-bit operation class. A second decoder combines that class with the function field and produces a 4-bit ALU select. The integration bench fills both arrays through a word-wide load port while reset is held. It then releases reset and watches the core through a registered trace of each register-file write, each data-memory write and the program counter.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, sampled on the rising edge, the PC becomes 0, no register or data-memory write takes place, and every trace output reads 0 after that edge.
- R2: An instruction that is not a taken branch advances the PC by 4. Instruction memory is indexed by PC bits [7:2] and wraps around past the last word.
- R3: Opcode 000000 writes rd (bits 15-11) with the result of rs (bits 25-21) and rt (bits 20-16), selected by funct (bits 5-0): 100000 add, 100010 subtract, 100100 and, 100101 or, 100110 xor, 100111 nor, 101010 signed less-than (result 1 or 0).
- R4: Opcode 100011 writes rt with the data word at address rs + sign-extended bits 15-0. The word index is address bits [7:2].
- R5: Opcode 101011 stores rt to the data word at rs + sign-extended bits 15-0 and does not write the register file.
- R6: Opcode 000100 with rs equal to rt loads the PC with PC+4 plus the sign-extended offset shifted left by 2. Negative offsets are included. When rs differs from rt, the next PC is PC+4.
- R7: Register 0 always reads as zero. A write that targets it is reported on the trace but leaves the register unchanged.
- R8: Any other opcode changes no register and no memory word, and the PC moves on by 4.
- R9: With `ld_we` high, `ld_data` is written on the clock edge to instruction word `ld_addr` (`ld_dmem`=0) or to data word `ld_addr` (`ld_dmem`=1).
- R10: The trace outputs show, one edge late, the register write and the data-memory write of the instruction that executed in the previous cycle. The store trace shows the byte address and the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load target: 0 instruction array, 1 data array |
| ld_addr | input | 6 | Load word index |
| ld_data | input | 32 | Load word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Trace: register write happened |
| rf_wa_o | output | 5 | Trace: register written |
| rf_wd_o | output | 32 | Trace: value written |
| dm_we_o | output | 1 | Trace: store happened |
| dm_wa_o | output | 32 | Trace: store byte address |
| dm_wd_o | output | 32 | Trace: stored word |

## Verification
Some cases cannot be forced from the ports in a single step. A backward branch is one: its register comparison changes from pass to pass. Another is a store that uses a negative offset from a base loaded at run time. A third is the instruction-memory wrap. The program therefore contains a counting loop that closes with a backward taken branch and leaves through a forward branch. It also contains a store addressed below a loaded base, and it runs long enough for the PC to wrap and run the whole program again on state it changed itself. A behavioural model in the bench steps through the same program and is compared after every edge.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_FN  = 2'b10
  } op_class_e;

  // bit 3: invert b with carry-in, bit 2: arithmetic path, bits 1:0 pick within path
  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_XOR = 4'b0010,
    ALU_NOR = 4'b0011,
    ALU_ADD = 4'b0110,
    ALU_SUB = 4'b1110,
    ALU_SLT = 4'b1111
  } alu_sel_e;

  typedef struct packed {
    logic      dst_is_rd;
    logic      b_is_imm;
    logic      wb_is_mem;
    logic      rf_wr;
    logic      mem_rd;
    logic      mem_wr;
    logic      is_beq;
    op_class_e cls;
  } ctrl_t;

endpackage

// File: rtl/core_main_dec.sv
module core_main_dec
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl     = '0;
    ctrl.cls = CLS_MEM;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.rf_wr     = 1'b1;
        ctrl.cls       = CLS_FN;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.wb_is_mem = 1'b1;
        ctrl.rf_wr     = 1'b1;
        ctrl.mem_rd    = 1'b1;
      end
      OPC_STOR: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_wr   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.is_beq = 1'b1;
        ctrl.cls    = CLS_BR;
      end
      default: ctrl.cls = CLS_MEM;
    endcase
  end

endmodule

// File: rtl/core_alu_dec.sv
module core_alu_dec
  import core_pkg::*;
(
  input  op_class_e  cls,
  input  logic [5:0] funct,
  output alu_sel_e   sel
);

  always_comb begin
    case (cls)
      CLS_MEM: sel = ALU_ADD;
      CLS_BR:  sel = ALU_SUB;
      CLS_FN: begin
        case (funct)
          FN_ADD:  sel = ALU_ADD;
          FN_SUB:  sel = ALU_SUB;
          FN_AND:  sel = ALU_AND;
          FN_OR:   sel = ALU_OR;
          FN_XOR:  sel = ALU_XOR;
          FN_NOR:  sel = ALU_NOR;
          FN_SLT:  sel = ALU_SLT;
          default: sel = ALU_ADD;
        endcase
      end
      default: sel = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  alu_sel_e      sel,
  output logic [XW-1:0] y,
  output logic          zero
);

  logic [3:0]    c;
  logic [XW-1:0] b_eff;
  logic [XW-1:0] sum;
  logic          lt;

  assign c     = sel;
  assign b_eff = c[3] ? ~b : b;
  assign sum   = a + b_eff + {{(XW-1){1'b0}}, c[3]};
  // signed less-than: operand signs decide when they differ, else the difference sign
  assign lt    = (a[XW-1] ^ b[XW-1]) ? a[XW-1] : sum[XW-1];

  always_comb begin
    if (c[2]) begin
      y = c[0] ? {{(XW-1){1'b0}}, lt} : sum;
    end else begin
      case (c[1:0])
        2'b00:   y = a & b;
        2'b01:   y = a | b;
        2'b10:   y = a ^ b;
        default: y = ~(a | b);
      endcase
    end
  end

  assign zero = (y == '0);

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int XW   = 32,
  parameter int NREG = 32,
  parameter int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [XW-1:0]  wd,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  output logic [XW-1:0]  rd1,
  output logic [XW-1:0]  rd2
);

  logic [XW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import core_pkg::*;
#(
  parameter int XW      = 32,
  parameter int NREG    = 32,
  parameter int IWORDS  = 64,
  parameter int DWORDS  = 64,
  parameter int IAW     = $clog2(IWORDS),
  parameter int DAW     = $clog2(DWORDS),
  parameter int LDAW    = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic            ld_dmem,
  input  logic [LDAW-1:0] ld_addr,
  input  logic [31:0]     ld_data,
  output logic [31:0]     pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_wa_o,
  output logic [31:0]     rf_wd_o,
  output logic            dm_we_o,
  output logic [31:0]     dm_wa_o,
  output logic [31:0]     dm_wd_o
);

  localparam int RAW = $clog2(NREG);

  logic [31:0]   pc;
  logic [31:0]   instr;
  logic [31:0]   imem [IWORDS];
  logic [XW-1:0] dmem [DWORDS];

  logic [5:0]    opcode;
  logic [5:0]    funct;
  logic [RAW-1:0] rs, rt, rd, wa;
  logic [15:0]   imm;
  logic [4:0]    unused_shamt;
  logic [31:0]   imm_ext;
  logic [31:0]   pc_next4;
  logic [31:0]   br_tgt;
  logic          take_br;

  ctrl_t         ctrl;
  alu_sel_e      alu_sel;
  logic [XW-1:0] rd1, rd2, alu_b, alu_y, dm_rdata, wb_data;
  logic          alu_zero;
  logic          rf_we_int, dm_we_int;
  logic [DAW-1:0] dm_idx;

  // instruction fetch and field split
  assign instr        = imem[IAW'(pc >> 2)];
  assign opcode       = instr[31:26];
  assign rs           = instr[25:21];
  assign rt           = instr[20:16];
  assign rd           = instr[15:11];
  assign unused_shamt = instr[10:6];
  assign funct        = instr[5:0];
  assign imm          = instr[15:0];
  assign imm_ext      = {{16{imm[15]}}, imm};

  core_main_dec u_main_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  core_alu_dec u_alu_dec (
    .cls   (ctrl.cls),
    .funct (funct),
    .sel   (alu_sel)
  );

  assign wa        = ctrl.dst_is_rd ? rd : rt;
  assign rf_we_int = ctrl.rf_wr && !rst;
  assign dm_we_int = ctrl.mem_wr && !rst;

  core_regfile #(.XW(XW), .NREG(NREG), .RAW(RAW)) u_rf (
    .clk (clk),
    .we  (rf_we_int),
    .wa  (wa),
    .wd  (wb_data),
    .ra1 (rs),
    .ra2 (rt),
    .rd1 (rd1),
    .rd2 (rd2)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : rd2;

  core_alu #(.XW(XW)) u_alu (
    .a    (rd1),
    .b    (alu_b),
    .sel  (alu_sel),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: one write port shared by the loader and stores
  assign dm_idx   = DAW'(alu_y >> 2);
  assign dm_rdata = dmem[dm_idx];
  assign wb_data  = ctrl.wb_is_mem ? dm_rdata : alu_y;

  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem)   dmem[DAW'(ld_addr)] <= ld_data;
    else if (dm_we_int)     dmem[dm_idx]        <= rd2;
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[IAW'(ld_addr)] <= ld_data;
  end

  // next PC
  assign pc_next4 = pc + 32'd4;
  assign br_tgt   = pc_next4 + {imm_ext[29:0], 2'b00};
  assign take_br  = ctrl.is_beq && alu_zero;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= take_br ? br_tgt : pc_next4;
  end

  assign pc_o = pc;

  // registered commit trace
  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we_o <= 1'b0;
      rf_wa_o <= '0;
      rf_wd_o <= '0;
      dm_we_o <= 1'b0;
      dm_wa_o <= '0;
      dm_wd_o <= '0;
    end else begin
      rf_we_o <= rf_we_int;
      rf_wa_o <= wa;
      rf_wd_o <= wb_data;
      dm_we_o <= dm_we_int;
      dm_wa_o <= alu_y;
      dm_wd_o <= rd2;
    end
  end

  // ---------------- assertions ----------------
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pc_o == 32'd0 && !rf_we_o && !dm_we_o));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!rst && !take_br) |=> (pc == $past(pc) + 32'd4));

  p_addr_calc_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.mem_rd || ctrl.mem_wr) |-> (alu_y == rd1 + imm_ext));

  p_store_no_rf_r5: assert property (@(posedge clk) disable iff (rst)
    dm_we_int |-> !rf_we_int);

  p_beq_compare_r6: assert property (@(posedge clk) disable iff (rst)
    ctrl.is_beq |-> (alu_zero == (rd1 == rd2)));

  p_br_target_r6: assert property (@(posedge clk) disable iff (rst)
    (!rst && take_br) |=> (pc == $past(br_tgt)));

  p_r0_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rs == '0) |-> (rd1 == '0));

  p_ctrl_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.mem_rd, ctrl.mem_wr, ctrl.is_beq, ctrl.dst_is_rd}));

  p_trace_lag_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (rf_we_o == $past(rf_we_int) && dm_we_o == $past(dm_we_int)));

endmodule

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, rf_wd_o, dm_wa_o, dm_wd_o;
  logic [4:0]  rf_wa_o;
  logic        rf_we_o, dm_we_o;

  always #2.5 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o), .rf_wd_o(rf_wd_o),
    .dm_we_o(dm_we_o), .dm_wa_o(dm_wa_o), .dm_wd_o(dm_wd_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_im [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;

  logic        e_rwe, e_dwe;
  logic [4:0]  e_rwa;
  logic [31:0] e_rwd, e_dwa, e_dwd, e_pc;
  string       e_tag, e_pctag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    logic [4:0] s5 = s[4:0];
    logic [4:0] t5 = t[4:0];
    logic [4:0] d5 = d[4:0];
    return {6'b000000, s5, t5, d5, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    logic [4:0]  s5 = s[4:0];
    logic [4:0]  t5 = t[4:0];
    logic [15:0] i16 = imm[15:0];
    return {op, s5, t5, i16};
  endfunction

  // behavioural reference: one instruction per call
  task automatic model_step();
    logic [31:0] ins, a, b, res, sx, addr;
    logic [5:0]  op, fn;
    int s, t, d;
    ins = m_im[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    s = int'(ins[25:21]); t = int'(ins[20:16]); d = int'(ins[15:11]);
    a = m_rf[s]; b = m_rf[t];
    sx = {{16{ins[15]}}, ins[15:0]};
    e_rwe = 0; e_dwe = 0; e_rwa = '0; e_rwd = '0; e_dwa = '0; e_dwd = '0;
    e_pc = m_pc + 4; e_pctag = "R2";
    case (op)
      6'b000000: begin
        case (fn)
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b100110: res = a ^ b;
          6'b100111: res = ~(a | b);
          default:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
        e_rwe = 1; e_rwa = d[4:0]; e_rwd = res;
        e_tag = (s == 0 || t == 0 || d == 0) ? "R3/R7/R10" : "R3/R10";
        if (d != 0) m_rf[d] = res;
      end
      6'b100011: begin
        addr = a + sx;
        e_rwe = 1; e_rwa = t[4:0]; e_rwd = m_dm[addr[7:2]];
        e_tag = (s == 0) ? "R4/R9/R10" : "R4/R10";
        if (t != 0) m_rf[t] = e_rwd;
      end
      6'b101011: begin
        addr = a + sx;
        e_dwe = 1; e_dwa = addr; e_dwd = b;
        e_tag = "R5/R10";
        m_dm[addr[7:2]] = b;
      end
      6'b000100: begin
        e_tag = "R6";
        e_pctag = "R6";
        if (a == b) e_pc = m_pc + 4 + {sx[29:0], 2'b00};
      end
      default: e_tag = "R8";
    endcase
    m_pc = e_pc;
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2: watchdog expired, core hung");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_im[i] = 32'h0;
      m_dm[i] = 32'd7 + 32'(i) * 32'd3;
    end
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    m_dm[0] = 32'h0000_0005;
    m_dm[1] = 32'hFFFF_FFF0;
    m_dm[2] = 32'h0F0F_1234;
    m_dm[3] = 32'h0000_0003;
    m_dm[6] = 32'd40;

    m_im[0]  = enc_i(6'b100011, 0, 1, 0);
    m_im[1]  = enc_i(6'b100011, 0, 2, 4);
    m_im[2]  = enc_i(6'b100011, 0, 3, 8);
    m_im[3]  = enc_i(6'b100011, 0, 4, 12);
    m_im[4]  = enc_r(1, 2, 5, 6'b100000);
    m_im[5]  = enc_r(1, 2, 6, 6'b100010);
    m_im[6]  = enc_r(3, 2, 7, 6'b100100);
    m_im[7]  = enc_r(3, 1, 8, 6'b100101);
    m_im[8]  = enc_r(3, 2, 9, 6'b100110);
    m_im[9]  = enc_r(3, 1, 10, 6'b100111);
    m_im[10] = enc_r(2, 1, 11, 6'b101010);
    m_im[11] = enc_r(1, 2, 12, 6'b101010);
    m_im[12] = enc_r(1, 1, 0, 6'b100000);
    m_im[13] = enc_r(0, 4, 13, 6'b100000);
    m_im[14] = enc_i(6'b101011, 0, 5, 20);
    m_im[15] = enc_i(6'b100011, 0, 14, 20);
    m_im[16] = enc_i(6'b100011, 0, 16, 24);
    m_im[17] = enc_i(6'b101011, 16, 6, -8);
    m_im[18] = enc_i(6'b100011, 0, 17, 32);
    m_im[19] = enc_i(6'b000100, 1, 2, 5);
    m_im[20] = enc_i(6'b000100, 4, 13, 2);
    m_im[21] = enc_r(1, 1, 18, 6'b100000);
    m_im[22] = enc_r(1, 1, 19, 6'b100000);
    m_im[23] = 32'hFC00_0000;
    m_im[24] = enc_i(6'b001000, 0, 1, 99);
    m_im[25] = enc_r(1, 0, 20, 6'b100000);
    m_im[26] = enc_r(0, 0, 21, 6'b100000);
    m_im[27] = enc_r(21, 1, 21, 6'b100000);
    m_im[28] = enc_r(21, 16, 22, 6'b101010);
    m_im[29] = enc_i(6'b000100, 22, 0, 1);
    m_im[30] = enc_i(6'b000100, 0, 0, -4);
    m_im[31] = enc_i(6'b101011, 0, 21, 36);

    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 rf_we", {31'b0, rf_we_o}, 32'h0);
    chk("R1 dm_we", {31'b0, dm_we_o}, 32'h0);

    // R9: preload both arrays while reset is held
    for (int i = 0; i < 64; i++) begin
      ld_we = 1; ld_dmem = 0; ld_addr = 6'(i); ld_data = m_im[i];
      @(negedge clk);
    end
    for (int i = 0; i < 64; i++) begin
      ld_we = 1; ld_dmem = 1; ld_addr = 6'(i); ld_data = m_dm[i];
      @(negedge clk);
    end
    ld_we = 0;
    chk("R1 pc held in reset", pc_o, 32'h0);
    rst = 0;

    for (int k = 0; k < 160; k++) begin
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(e_pctag, pc_o, e_pc);
      chk(e_tag, {31'b0, rf_we_o}, {31'b0, e_rwe});
      if (e_rwe) begin
        chk(e_tag, {27'b0, rf_wa_o}, {27'b0, e_rwa});
        chk(e_tag, rf_wd_o, e_rwd);
      end
      chk(e_tag, {31'b0, dm_we_o}, {31'b0, e_dwe});
      if (e_dwe) begin
        chk(e_tag, dm_wa_o, e_dwa);
        chk(e_tag, dm_wd_o, e_dwd);
      end
    end

    // R1: reset reasserted mid-run
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc after reset", pc_o, 32'h0);
    chk("R1 rf trace cleared", {31'b0, rf_we_o}, 32'h0);
    chk("R1 dm trace cleared", {31'b0, dm_we_o}, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule